// File: doc/BRIEF.md
# Receiver PMA Reset Sequencer

This controller carries out a receive-side PMA reset on one serial transceiver channel, with a configuration patch wrapped around the reset pulse. When a start request is accepted, it reads one configuration word through the channel's reconfiguration port and writes it back with a single control bit forced to zero. All other bits keep the value that was read. Only after that write is acknowledged does it raise the PMA reset.

With the reset held high, the controller waits for the channel's reset-done flag to go low. It then writes the saved word back unchanged, which restores the control bit. After the restore write is acknowledged, it holds the reset for a programmable number of extra cycles and then releases it. A watchdog timer covers the wait for the done flag. If the flag never falls, the sequence still restores the word and releases the reset, but it flags an error together with its done pulse.

Port accesses use a one-cycle enable strobe and a one-cycle ready response. Arbitration with other port masters lies outside the block.

Top module: `rx_pma_reset_seq`

## Requirements
- R1: The first access of every sequence is a read (enable high, write-enable low) at address CFG_ADDR, 9'h011 by default.
- R2: The second access is a write to CFG_ADDR. Its data equals the word read with bit CLR_BIT (11 by default) cleared, and every other bit unchanged.
- R3: The PMA reset output rises exactly two clock edges after the edge that samples ready for the clearing write. It never rises earlier.
- R4: With the reset high, the restore write is issued on the edge that first samples the reset-done input low.
- R5: The third and last access is a write to CFG_ADDR of the originally read word, unchanged.
- R6: The reset output stays high until the restore write is acknowledged. It falls exactly RELEASE_HOLD + 2 clock edges after the edge that samples ready for that write.
- R7: Every port access holds enable high for exactly one cycle, and a new access starts only after the previous access has received ready.
- R8: A start that arrives while busy is ignored, so each sequence makes exactly three accesses and produces one done pulse. Busy rises on the edge that accepts start and falls on the edge that lowers the reset. Done is a one-cycle pulse on that same edge.
- R9: If reset-done is still high on TIMEOUT_CYC consecutive wait edges, the restore write is issued on the last of those edges. The sequence then completes normally, with error high during the done pulse. If the flag falls on that same edge, the fall wins and no error is reported.
- R10: While the synchronous active-high reset is asserted, the PMA reset, enable, busy and done outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high controller reset |
| start_i | input | 1 | Request to run one reset sequence |
| busy_o | output | 1 | High while a sequence is in progress |
| done_o | output | 1 | One-cycle pulse when the reset is released |
| error_o | output | 1 | High with done when the reset-done wait timed out |
| cfg_addr_o | output | ADDR_W | Port address |
| cfg_en_o | output | 1 | Port access strobe, one cycle |
| cfg_we_o | output | 1 | Port write-enable, valid with the strobe |
| cfg_wdata_o | output | DATA_W | Port write data |
| cfg_rdata_i | input | DATA_W | Port read data, valid with ready |
| cfg_rdy_i | input | 1 | Port access complete, one cycle |
| rx_pma_rst_o | output | 1 | PMA reset to the channel, registered |
| rx_pma_rst_done_i | input | 1 | PMA reset-done flag from the channel |

## Verification
The reset-done flag falling and the watchdog expiring can land on the same clock edge. Both would trigger the restore write, and only one of them may be reported. The bench provokes this by lowering the flag on exactly the last allowed wait edge, which must give a clean completion without error. It then lowers the flag one edge later, which must give a timed-out completion with error. In both runs the restore write must appear on the expiry edge.

// File: rtl/pmaseq_pkg.sv
package pmaseq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_READ,
        SQ_CLEAR,
        SQ_WAITLO,
        SQ_RESTORE,
        SQ_HOLD
    } seq_state_e;

endpackage

// File: rtl/pmaseq_timer.sv
module pmaseq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;

    // the count only ever restarts from zero or moves up by one
    assert_timer_step_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(clear_i) && !$past(rst) |-> (cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == CNT_MAX));

endmodule

// File: rtl/pmaseq_port_master.sv
module pmaseq_port_master #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              idle_o,
    output logic              ack_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              cfg_en_o,
    output logic              cfg_we_o,
    output logic [ADDR_W-1:0] cfg_addr_o,
    output logic [DATA_W-1:0] cfg_wdata_o,
    input  logic [DATA_W-1:0] cfg_rdata_i,
    input  logic              cfg_rdy_i
);
    typedef struct packed {
        logic              pend;
        logic              en;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              ack;
        logic [DATA_W-1:0] rdata;
    } pm_state_t;

    pm_state_t pm_d, pm_q;

    always_comb begin
        pm_d     = pm_q;
        pm_d.en  = 1'b0;
        pm_d.ack = 1'b0;
        if (!pm_q.pend) begin
            if (req_i) begin
                pm_d.pend  = 1'b1;
                pm_d.en    = 1'b1;
                pm_d.we    = we_i;
                pm_d.addr  = addr_i;
                pm_d.wdata = wdata_i;
            end
        end else if (cfg_rdy_i) begin
            pm_d.pend = 1'b0;
            pm_d.ack  = 1'b1;
            if (!pm_q.we) begin
                pm_d.rdata = cfg_rdata_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pm_q <= '0;
        else     pm_q <= pm_d;
    end

    assign idle_o      = !pm_q.pend;
    assign ack_o       = pm_q.ack;
    assign rdata_o     = pm_q.rdata;
    assign cfg_en_o    = pm_q.en;
    assign cfg_we_o    = pm_q.we;
    assign cfg_addr_o  = pm_q.addr;
    assign cfg_wdata_o = pm_q.wdata;

    assert_en_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        cfg_en_o |=> !cfg_en_o);

    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (rst)
        req_i |-> idle_o);

    assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> !ack_o);

endmodule

// File: rtl/rx_pma_reset_seq.sv
module rx_pma_reset_seq
    import pmaseq_pkg::*;
#(
    parameter int              ADDR_W       = 9,
    parameter int              DATA_W       = 16,
    parameter logic [ADDR_W-1:0] CFG_ADDR   = 9'h011,
    parameter int              CLR_BIT      = 11,
    parameter int              TIMEOUT_CYC  = 4096,
    parameter int              RELEASE_HOLD = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              error_o,
    output logic [ADDR_W-1:0] cfg_addr_o,
    output logic              cfg_en_o,
    output logic              cfg_we_o,
    output logic [DATA_W-1:0] cfg_wdata_o,
    input  logic [DATA_W-1:0] cfg_rdata_i,
    input  logic              cfg_rdy_i,
    output logic              rx_pma_rst_o,
    input  logic              rx_pma_rst_done_i
);
    localparam int TO_W   = $clog2(TIMEOUT_CYC + 1);
    localparam int HOLD_W = (RELEASE_HOLD > 0) ? $clog2(RELEASE_HOLD + 1) : 1;
    localparam logic [TO_W-1:0]   TO_LAST   = TO_W'(TIMEOUT_CYC - 1);
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'((RELEASE_HOLD > 0) ? RELEASE_HOLD - 1 : 0);
    localparam logic [DATA_W-1:0] CLR_MASK  = DATA_W'(1) << CLR_BIT;

    typedef struct packed {
        seq_state_e        state;
        logic              pma_rst;
        logic              busy;
        logic              done;
        logic              err;
        logic              restored;
        logic [DATA_W-1:0] saved;
        logic [HOLD_W-1:0] hold_cnt;
    } seq_t;

    seq_t sq_d, sq_q;

    logic              pm_req, pm_we, pm_idle, pm_ack;
    logic [DATA_W-1:0] pm_wdata, pm_rdata;
    logic [TO_W-1:0]   wait_cnt;
    logic              timer_clear;

    assign timer_clear = (sq_q.state != SQ_WAITLO);

    pmaseq_timer #(.CNT_W(TO_W)) u_wait_timer (
        .clk     (clk),
        .rst     (rst),
        .clear_i (timer_clear),
        .count_o (wait_cnt)
    );

    pmaseq_port_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
        .clk         (clk),
        .rst         (rst),
        .req_i       (pm_req),
        .we_i        (pm_we),
        .addr_i      (CFG_ADDR),
        .wdata_i     (pm_wdata),
        .idle_o      (pm_idle),
        .ack_o       (pm_ack),
        .rdata_o     (pm_rdata),
        .cfg_en_o    (cfg_en_o),
        .cfg_we_o    (cfg_we_o),
        .cfg_addr_o  (cfg_addr_o),
        .cfg_wdata_o (cfg_wdata_o),
        .cfg_rdata_i (cfg_rdata_i),
        .cfg_rdy_i   (cfg_rdy_i)
    );

    // next-state logic for the sequence
    always_comb begin
        sq_d      = sq_q;
        sq_d.done = 1'b0;
        pm_req    = 1'b0;
        pm_we     = 1'b0;
        pm_wdata  = sq_q.saved;
        unique case (sq_q.state)
            SQ_IDLE: begin
                if (start_i) begin
                    pm_req        = 1'b1;
                    sq_d.busy     = 1'b1;
                    sq_d.err      = 1'b0;
                    sq_d.restored = 1'b0;
                    sq_d.state    = SQ_READ;
                end
            end
            SQ_READ: begin
                if (pm_ack) begin
                    sq_d.saved = pm_rdata;
                    pm_req     = 1'b1;
                    pm_we      = 1'b1;
                    pm_wdata   = pm_rdata & ~CLR_MASK;
                    sq_d.state = SQ_CLEAR;
                end
            end
            SQ_CLEAR: begin
                if (pm_ack) begin
                    sq_d.pma_rst = 1'b1;
                    sq_d.state   = SQ_WAITLO;
                end
            end
            SQ_WAITLO: begin
                if (!rx_pma_rst_done_i || wait_cnt == TO_LAST) begin
                    pm_req     = 1'b1;
                    pm_we      = 1'b1;
                    pm_wdata   = sq_q.saved;
                    sq_d.err   = rx_pma_rst_done_i;
                    sq_d.state = SQ_RESTORE;
                end
            end
            SQ_RESTORE: begin
                if (pm_ack) begin
                    sq_d.restored = 1'b1;
                    sq_d.hold_cnt = '0;
                    if (RELEASE_HOLD == 0) begin
                        sq_d.pma_rst = 1'b0;
                        sq_d.busy    = 1'b0;
                        sq_d.done    = 1'b1;
                        sq_d.state   = SQ_IDLE;
                    end else begin
                        sq_d.state   = SQ_HOLD;
                    end
                end
            end
            SQ_HOLD: begin
                if (sq_q.hold_cnt == HOLD_LAST) begin
                    sq_d.pma_rst = 1'b0;
                    sq_d.busy    = 1'b0;
                    sq_d.done    = 1'b1;
                    sq_d.state   = SQ_IDLE;
                end else begin
                    sq_d.hold_cnt = sq_q.hold_cnt + 1'b1;
                end
            end
            default: sq_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sq_q       <= '0;
            sq_q.state <= SQ_IDLE;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign busy_o       = sq_q.busy;
    assign done_o       = sq_q.done;
    assign error_o      = sq_q.done && sq_q.err;
    assign rx_pma_rst_o = sq_q.pma_rst;

    assert_read_addr_R1: assert property (@(posedge clk) disable iff (rst)
        cfg_en_o && !cfg_we_o |-> cfg_addr_o == CFG_ADDR);

    assert_clear_data_R2: assert property (@(posedge clk) disable iff (rst)
        cfg_en_o && cfg_we_o && !rx_pma_rst_o |-> cfg_wdata_o == (sq_q.saved & ~CLR_MASK));

    assert_rise_after_clear_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_pma_rst_o) && !$past(rst) |-> $past(pm_ack && sq_q.state == SQ_CLEAR));

    assert_restore_after_low_R4: assert property (@(posedge clk) disable iff (rst)
        cfg_en_o && cfg_we_o && rx_pma_rst_o |-> $past(!rx_pma_rst_done_i) || sq_q.err);

    assert_restore_data_R5: assert property (@(posedge clk) disable iff (rst)
        cfg_en_o && cfg_we_o && rx_pma_rst_o |-> cfg_wdata_o == sq_q.saved);

    assert_hold_until_restored_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_pma_rst_o) && !$past(rst) |-> sq_q.restored);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o && !rx_pma_rst_o);

    assert_error_with_done_R9: assert property (@(posedge clk) disable iff (rst)
        error_o |-> done_o);

    assert_reset_quiet_R10: assert property (@(posedge clk)
        rst |=> !rx_pma_rst_o && !cfg_en_o && !busy_o && !done_o);

endmodule

// File: tb/rx_pma_reset_seq_tb.sv
`timescale 1ns/1ps
module rx_pma_reset_seq_tb;
    localparam int TO   = 20;
    localparam int HOLD = 2;
    localparam int CB   = 11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        busy_o, done_o, error_o;
    logic [8:0]  cfg_addr_o;
    logic        cfg_en_o, cfg_we_o;
    logic [15:0] cfg_wdata_o;
    logic [15:0] cfg_rdata_i = '0;
    logic        cfg_rdy_i = 1'b0;
    logic        rx_pma_rst_o;
    logic        rx_pma_rst_done_i = 1'b1;

    rx_pma_reset_seq #(
        .ADDR_W(9), .DATA_W(16), .CFG_ADDR(9'h011), .CLR_BIT(CB),
        .TIMEOUT_CYC(TO), .RELEASE_HOLD(HOLD)
    ) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
        .error_o(error_o), .cfg_addr_o(cfg_addr_o), .cfg_en_o(cfg_en_o),
        .cfg_we_o(cfg_we_o), .cfg_wdata_o(cfg_wdata_o), .cfg_rdata_i(cfg_rdata_i),
        .cfg_rdy_i(cfg_rdy_i), .rx_pma_rst_o(rx_pma_rst_o),
        .rx_pma_rst_done_i(rx_pma_rst_done_i)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // port model and monitors, all acting at the falling edge
    logic [15:0] reg_val = '0;
    bit          pend = 0, pwe = 0, prev_en = 0, prev_pma = 0, prev_busy = 0;
    int          pdly = 0;
    logic [15:0] pwdata = '0;
    int          n_txn, n_rsp, overlap, en_long, done_cnt, err_cnt, stray_err;
    bit          t_we [4];
    logic [8:0]  t_addr [4];
    logic [15:0] t_data [4];
    int          t_en_cyc [4];
    int          t_rdy_cyc [4];
    int          rise_cyc, fall_cyc, drop_cyc, done_cyc, busy_fall;
    bit          drop_en = 0;
    int          drop_dly = 0;

    always @(negedge clk) begin
        cfg_rdy_i = 1'b0;
        if (pend) begin
            if (pdly == 0) begin
                cfg_rdy_i = 1'b1;
                pend = 0;
                if (n_rsp < 4) t_rdy_cyc[n_rsp] = cyc;
                n_rsp++;
                if (pwe) reg_val = pwdata;
                else     cfg_rdata_i = reg_val;
            end else begin
                pdly--;
            end
        end
        if (cfg_en_o) begin
            if (pend) overlap++;
            if (prev_en) en_long++;
            pend   = 1;
            pdly   = $urandom_range(0, 3);
            pwe    = cfg_we_o;
            pwdata = cfg_wdata_o;
            if (n_txn < 4) begin
                t_we[n_txn]     = cfg_we_o;
                t_addr[n_txn]   = cfg_addr_o;
                t_data[n_txn]   = cfg_wdata_o;
                t_en_cyc[n_txn] = cyc;
            end
            n_txn++;
        end
        prev_en = cfg_en_o;
        if (rx_pma_rst_o && !prev_pma) rise_cyc = cyc;
        if (!rx_pma_rst_o && prev_pma) fall_cyc = cyc;
        if (rx_pma_rst_o && drop_en && rx_pma_rst_done_i && cyc == rise_cyc + drop_dly) begin
            rx_pma_rst_done_i = 1'b0;
            drop_cyc = cyc;
        end
        if (!rx_pma_rst_o) rx_pma_rst_done_i = 1'b1;
        prev_pma = rx_pma_rst_o;
        if (done_o) begin
            done_cnt++;
            done_cyc = cyc;
            if (error_o) err_cnt++;
        end
        if (error_o && !done_o) stray_err++;
        if (prev_busy && !busy_o) busy_fall = cyc;
        prev_busy = busy_o;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] cleared(input logic [15:0] v);
        return v & ~(16'h1 << CB);
    endfunction

    function automatic int exp_fall(input int restore_rdy);
        return restore_rdy + 2 + HOLD;
    endfunction

    task automatic clear_logs();
        n_txn = 0; n_rsp = 0; overlap = 0; en_long = 0;
        done_cnt = 0; err_cnt = 0; stray_err = 0;
        rise_cyc = -1; fall_cyc = -1; drop_cyc = -1; done_cyc = -1; busy_fall = -1;
    endtask

    // mode 0: drop reset-done after dly cycles; mode 1: never drop
    task automatic run_seq(input logic [15:0] init, input int mode, input int dly,
                           input bit exp_err, input bit extra_start);
        int waited;
        bit expected_err;
        reg_val  = init;
        clear_logs();
        drop_en  = (mode == 0);
        drop_dly = dly;
        expected_err = exp_err;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        check(busy_o == 1'b1, "R8", "busy after start", busy_o, 1);
        waited = 0;
        while (done_cnt == 0 && waited < 1000) begin
            @(negedge clk);
            waited++;
            start_i = extra_start && (waited == 4 || waited == 9);
        end
        start_i = 1'b0;
        repeat (6) @(negedge clk);
        check(done_cnt == 1, "R8", "done pulses", done_cnt, 1);
        check(n_txn == 3, "R8", "accesses per sequence", n_txn, 3);
        check(overlap == 0 && en_long == 0, "R7", "enable overlap/width", overlap + en_long, 0);
        check(!t_we[0] && t_addr[0] == 9'h011, "R1", "read addr", t_addr[0], 9'h011);
        check(t_we[1] && t_addr[1] == 9'h011, "R2", "clear write addr", t_addr[1], 9'h011);
        check(t_data[1] == cleared(init), "R2", "clear write data", t_data[1], cleared(init));
        check(rise_cyc == t_rdy_cyc[1] + 2, "R3", "reset rise cycle", rise_cyc, t_rdy_cyc[1] + 2);
        check(t_we[2] && t_addr[2] == 9'h011, "R5", "restore write addr", t_addr[2], 9'h011);
        check(t_data[2] == init, "R5", "restore write data", t_data[2], init);
        check(reg_val == init, "R5", "register after sequence", reg_val, init);
        if (mode == 0 && !expected_err)
            check(t_en_cyc[2] == drop_cyc + 1, "R4", "restore after done low", t_en_cyc[2], drop_cyc + 1);
        if (expected_err)
            check(t_en_cyc[2] == rise_cyc + TO, "R9", "restore on expiry", t_en_cyc[2], rise_cyc + TO);
        check(fall_cyc == exp_fall(t_rdy_cyc[2]), "R6", "reset fall cycle", fall_cyc, exp_fall(t_rdy_cyc[2]));
        check(busy_fall == fall_cyc && done_cyc == fall_cyc, "R8", "busy/done at release",
              busy_fall, fall_cyc);
        check(err_cnt == (expected_err ? 1 : 0) && stray_err == 0, "R9", "error flag",
              err_cnt, expected_err ? 1 : 0);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        clear_logs();
        repeat (3) @(negedge clk);
        check(!rx_pma_rst_o && !cfg_en_o && !busy_o && !done_o, "R10", "outputs in reset",
              {rx_pma_rst_o, cfg_en_o, busy_o, done_o}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        run_seq(16'hFFFF, 0, 3, 0, 0);
        run_seq(16'h0000, 0, 0, 0, 1);
        run_seq(16'h0800, 0, 5, 0, 0);
        // same-edge race: done falls on the last allowed edge -> no error
        run_seq(16'hA5C3, 0, TO - 1, 0, 0);
        // one edge late -> timeout with error
        run_seq(16'h5A3C, 0, TO, 1, 0);
        // flag never falls
        run_seq(16'h1234, 1, 0, 1, 1);
        for (int i = 0; i < 8; i++) begin
            run_seq(16'($urandom()), 0, $urandom_range(0, TO - 2), 0, 1'($urandom_range(0, 1)));
        end

        // reset in the middle of a sequence
        reg_val = 16'hBEEF;
        clear_logs();
        drop_en = 0;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        for (int w = 0; w < 200 && !rx_pma_rst_o; w++) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(!rx_pma_rst_o && !cfg_en_o && !busy_o && !done_o, "R10", "mid-sequence reset",
              {rx_pma_rst_o, cfg_en_o, busy_o, done_o}, 0);
        @(negedge clk);
        pend = 0;
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(!rx_pma_rst_o && !busy_o, "R10", "idle after reset", {rx_pma_rst_o, busy_o}, 0);
        run_seq(16'h7FF1, 0, 2, 0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule